// File: doc/BRIEF.md
# CSR Instruction Access Unit

This unit carries out the six control-and-status register instructions (read-write, read-set and read-clear, each with a register operand or a 5-bit immediate operand) against a small machine-level register file that it holds itself. For each valid instruction it works out three things. It decides whether the CSR read takes place. It decides whether the CSR write takes place. It checks whether the access is allowed at all. It then forms the new register value and hands the previous value back for the destination register.

The CSR address carries the legality rules. Bits [9:8] give the least privileged level that may touch the register. Bits [11:10] equal to 2'b11 mark it read-only. An address outside the implemented set is refused. A refused access raises a one-cycle illegal flag and has no side effect. Every result appears on the outputs one clock edge after the valid input. The register update happens on that same edge, so the next instruction sees the new value.

Top module: `csr_access_unit`

## Requirements
- R1: funct3 selects the operation. 3'b001 is write, 3'b010 is set and 3'b011 is clear, each taking the register value as operand. 3'b101, 3'b110 and 3'b111 are the same three operations with the 5-bit source field zero-extended to 32 bits as operand. funct3 3'b000 or 3'b100 is flagged illegal.
- R2: A write-form instruction with destination index 0 updates the CSR but performs no CSR read: `csr_rd_o` and `rd_we_o` stay 0.
- R3: A set-form or clear-form instruction whose 5-bit source field is 0 reads the CSR and performs no write (`csr_we_o` = 0), whatever the register value input holds.
- R4: The write form stores the operand. The set form stores old OR operand. The clear form stores old AND NOT operand. The destination receives the old value.
- R5: An access is illegal when the privilege input (0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8].
- R6: An address outside the implemented set is illegal. The implemented set is 0x340 scratch, 0x300 status, 0x305 vector base, 0x140 supervisor scratch, 0xF12 read-only constant 0x5A5A0001 and 0xCC0 user read-only constant 0x00C0FFEE.
- R7: An access that would write a CSR with address bits [11:10] = 2'b11 is illegal. A register-operand set whose source index is nonzero counts as a write, even when the register value is zero.
- R8: On an illegal access no CSR changes, and `rd_we_o`, `csr_rd_o` and `csr_we_o` are all 0.
- R9: Status keeps only bits 7 and 3 of a write and reads the other bits as 0. Both scratch registers keep every written bit.
- R10: In the vector base register, a written mode field (bits [1:0]) of 2 or 3 is stored as 0. Bits [31:2] are stored unchanged.
- R11: `done_o` and all result outputs follow a valid input by exactly one clock edge. Reset clears every output and every CSR to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| funct3_i | input | 3 | Operation and operand kind |
| csr_addr_i | input | 12 | CSR address |
| src_i | input | 5 | Source register index or immediate |
| rs1_val_i | input | 32 | Source register value |
| rd_idx_i | input | 5 | Destination register index |
| priv_i | input | 2 | Current privilege level |
| done_o | output | 1 | Result valid |
| illegal_o | output | 1 | Illegal-instruction flag |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination index |
| rd_data_o | output | 32 | Old CSR value for the destination |
| csr_rd_o | output | 1 | A CSR read was performed |
| csr_we_o | output | 1 | A CSR write was performed |
| csr_waddr_o | output | 12 | Address written |
| csr_wdata_o | output | 32 | Value formed for the write, before field rules |

## Verification
Some rules are checked by assertions on every cycle. A write-form instruction to destination 0 never reads. A zero source field on set or clear never writes. A privilege shortfall always flags illegal. No write ever reaches a read-only address, and a flagged access has no side effect. The status register never holds bits outside its mask, and the vector mode never holds a reserved code. Other behaviour can only be shown by the bench's instruction sequences: the set and clear arithmetic, the zero extension of the immediate, the refusal of unimplemented addresses, and the fact that a refused write leaves the old contents in place.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 5;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLEAR} csr_op_e;

  localparam logic [11:0] A_SCRATCH  = 12'h340;
  localparam logic [11:0] A_STATUS   = 12'h300;
  localparam logic [11:0] A_VECTOR   = 12'h305;
  localparam logic [11:0] A_SSCRATCH = 12'h140;
  localparam logic [11:0] A_IDCONST  = 12'hF12;
  localparam logic [11:0] A_UCONST   = 12'hCC0;

  // operand: zero-extended immediate or register value
  function automatic logic [XLEN-1:0] csr_operand(input logic use_imm,
                                                  input logic [IMMW-1:0] imm,
                                                  input logic [XLEN-1:0] rval);
    return use_imm ? {{(XLEN-IMMW){1'b0}}, imm} : rval;
  endfunction

  function automatic logic [XLEN-1:0] csr_merge(input csr_op_e op,
                                                input logic [XLEN-1:0] old,
                                                input logic [XLEN-1:0] opnd);
    case (op)
      OP_WRITE: return opnd;
      OP_SET:   return old | opnd;
      OP_CLEAR: return old & ~opnd;
      default:  return old;
    endcase
  endfunction

  // reserved mode codes 2 and 3 fall back to 0
  function automatic logic [XLEN-1:0] vector_legalize(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], (v[1] ? 2'b00 : v[1:0])};
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic        valid_i,
  input  logic [2:0]  funct3_i,
  input  logic [11:0] addr_i,
  input  logic [4:0]  src_i,
  input  logic [4:0]  rd_i,
  input  logic [1:0]  priv_i,
  input  logic        hit_i,
  output csr_op_e     op_o,
  output logic        use_imm_o,
  output logic        do_read_o,
  output logic        do_write_o,
  output logic        illegal_o
);
  logic bad_f3, priv_low, ro_hit;

  always_comb begin
    case (funct3_i[1:0])
      2'b01:   op_o = OP_WRITE;
      2'b10:   op_o = OP_SET;
      2'b11:   op_o = OP_CLEAR;
      default: op_o = OP_NONE;
    endcase
    use_imm_o  = funct3_i[2];
    bad_f3     = (op_o == OP_NONE);
    do_read_o  = (op_o == OP_WRITE) ? (rd_i != 5'd0) : 1'b1;
    do_write_o = (op_o == OP_WRITE) ? 1'b1 : (src_i != 5'd0);
    priv_low   = (priv_i < addr_i[9:8]);
    ro_hit     = do_write_o && (addr_i[11:10] == 2'b11);
    illegal_o  = valid_i && (bad_f3 || priv_low || !hit_i || ro_hit);
  end
endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_pkg::*;
#(
  parameter logic [XLEN-1:0] STATUS_MASK = 32'h0000_0088,
  parameter logic [XLEN-1:0] ID_VALUE    = 32'h5A5A_0001,
  parameter logic [XLEN-1:0] UCONST_VAL  = 32'h00C0_FFEE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     raddr_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            hit_o,
  input  logic            we_i,
  input  logic [11:0]     waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] scratch_q, status_q, vector_q, sscratch_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      scratch_q  <= '0;
      status_q   <= '0;
      vector_q   <= '0;
      sscratch_q <= '0;
    end else if (we_i) begin
      case (waddr_i)
        A_SCRATCH:  scratch_q  <= wdata_i;
        A_STATUS:   status_q   <= wdata_i & STATUS_MASK;
        A_VECTOR:   vector_q   <= vector_legalize(wdata_i);
        A_SSCRATCH: sscratch_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit_o = 1'b1;
    case (raddr_i)
      A_SCRATCH:  rdata_o = scratch_q;
      A_STATUS:   rdata_o = status_q;
      A_VECTOR:   rdata_o = vector_q;
      A_SSCRATCH: rdata_o = sscratch_q;
      A_IDCONST:  rdata_o = ID_VALUE;
      A_UCONST:   rdata_o = UCONST_VAL;
      default: begin
        rdata_o = '0;
        hit_o   = 1'b0;
      end
    endcase
  end

  // R9
  status_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~STATUS_MASK) == '0);
  // R10
  vector_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vector_q[1]);
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_pkg::*;
#(
  parameter logic [XLEN-1:0] STATUS_MASK = 32'h0000_0088,
  parameter logic [XLEN-1:0] ID_VALUE    = 32'h5A5A_0001,
  parameter logic [XLEN-1:0] UCONST_VAL  = 32'h00C0_FFEE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      funct3_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [4:0]      src_i,
  input  logic [31:0]     rs1_val_i,
  input  logic [4:0]      rd_idx_i,
  input  logic [1:0]      priv_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic            rd_we_o,
  output logic [4:0]      rd_idx_o,
  output logic [31:0]     rd_data_o,
  output logic            csr_rd_o,
  output logic            csr_we_o,
  output logic [11:0]     csr_waddr_o,
  output logic [31:0]     csr_wdata_o
);
  csr_op_e         op;
  logic            use_imm, do_read, do_write, dec_illegal, hit;
  logic [XLEN-1:0] old_val, operand, new_val;
  logic            evt_fire, evt_read, evt_write;

  csr_decode u_dec (
    .valid_i(valid_i), .funct3_i(funct3_i), .addr_i(csr_addr_i),
    .src_i(src_i), .rd_i(rd_idx_i), .priv_i(priv_i), .hit_i(hit),
    .op_o(op), .use_imm_o(use_imm), .do_read_o(do_read),
    .do_write_o(do_write), .illegal_o(dec_illegal)
  );

  assign operand   = csr_operand(use_imm, src_i, rs1_val_i);
  assign new_val   = csr_merge(op, old_val, operand);
  assign evt_fire  = valid_i && !dec_illegal;
  assign evt_read  = evt_fire && do_read;
  assign evt_write = evt_fire && do_write;

  csr_file #(.STATUS_MASK(STATUS_MASK), .ID_VALUE(ID_VALUE), .UCONST_VAL(UCONST_VAL)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni), .raddr_i(csr_addr_i), .rdata_o(old_val),
    .hit_o(hit), .we_i(evt_write), .waddr_i(csr_addr_i), .wdata_i(new_val)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      illegal_o   <= 1'b0;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
      csr_rd_o    <= 1'b0;
      csr_we_o    <= 1'b0;
      csr_waddr_o <= '0;
      csr_wdata_o <= '0;
    end else begin
      done_o      <= valid_i;
      illegal_o   <= dec_illegal;
      rd_we_o     <= evt_fire && (rd_idx_i != 5'd0);
      rd_idx_o    <= rd_idx_i;
      rd_data_o   <= evt_read ? old_val : '0;
      csr_rd_o    <= evt_read;
      csr_we_o    <= evt_write;
      csr_waddr_o <= csr_addr_i;
      csr_wdata_o <= new_val;
    end
  end

  // R2
  rw_noread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && funct3_i[1:0] == 2'b01 && rd_idx_i == 5'd0 |=> !csr_rd_o);
  // R3
  zero_src_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && funct3_i[1] && src_i == 5'd0 |=> !csr_we_o);
  // R5
  priv_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && priv_i < csr_addr_i[9:8] |=> illegal_o);
  // R7
  ro_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> csr_waddr_o[11:10] != 2'b11);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !rd_we_o && !csr_we_o && !csr_rd_o);
  // R11
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
endmodule

// File: tb/csr_access_unit_tb.sv
`timescale 1ns/1ps
module csr_access_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  f3 = '0;
  logic [11:0] addr = '0;
  logic [4:0]  src = '0;
  logic [31:0] rs1v = '0;
  logic [4:0]  rd = '0;
  logic [1:0]  priv = 2'd3;
  logic        done, ill, rdwe, crd, cwe;
  logic [4:0]  rdidx;
  logic [31:0] rdata, cwdata;
  logic [11:0] cwaddr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  csr_access_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .funct3_i(f3),
    .csr_addr_i(addr), .src_i(src), .rs1_val_i(rs1v), .rd_idx_i(rd),
    .priv_i(priv), .done_o(done), .illegal_o(ill), .rd_we_o(rdwe),
    .rd_idx_o(rdidx), .rd_data_o(rdata), .csr_rd_o(crd), .csr_we_o(cwe),
    .csr_waddr_o(cwaddr), .csr_wdata_o(cwdata)
  );

  typedef struct packed {
    logic [2:0]  f3;
    logic [11:0] addr;
    logic [4:0]  src;
    logic [31:0] rs1;
    logic [4:0]  rd;
    logic [1:0]  priv;
    logic        ill;
    logic        rdwe;
    logic [31:0] rdat;
    logic        rflag;
    logic        we;
    logic [31:0] wdat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 12'h340, 5'd1,  32'hDEADBEEF, 5'd2,  2'd3, 1'b0, 1'b1, 32'h0,        1'b1, 1'b1, 32'hDEADBEEF, 4'd4},  // R4 write
    '{3'b010, 12'h340, 5'd3,  32'h000000F0, 5'd4,  2'd3, 1'b0, 1'b1, 32'hDEADBEEF, 1'b1, 1'b1, 32'hDEADBEFF, 4'd4},  // R4 set
    '{3'b011, 12'h340, 5'd3,  32'hDEAD0000, 5'd5,  2'd3, 1'b0, 1'b1, 32'hDEADBEFF, 1'b1, 1'b1, 32'h0000BEFF, 4'd4},  // R4 clear
    '{3'b111, 12'h340, 5'h1F, 32'hFFFFFFFF, 5'd6,  2'd3, 1'b0, 1'b1, 32'h0000BEFF, 1'b1, 1'b1, 32'h0000BEE0, 4'd1},  // R1 imm clear, zero-extended
    '{3'b110, 12'h340, 5'd0,  32'hFFFFFFFF, 5'd7,  2'd3, 1'b0, 1'b1, 32'h0000BEE0, 1'b1, 1'b0, 32'h0,        4'd3},  // R3 imm zero
    '{3'b101, 12'h340, 5'h15, 32'hFFFFFFFF, 5'd0,  2'd3, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 32'h00000015, 4'd2},  // R2 rd x0
    '{3'b010, 12'h340, 5'd0,  32'h0000FFFF, 5'd8,  2'd3, 1'b0, 1'b1, 32'h00000015, 1'b1, 1'b0, 32'h0,        4'd3},  // R3 x0 source
    '{3'b001, 12'h300, 5'd1,  32'hFFFFFFFF, 5'd0,  2'd3, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 32'hFFFFFFFF, 4'd9},  // R9 status write
    '{3'b010, 12'h300, 5'd0,  32'h0,        5'd9,  2'd3, 1'b0, 1'b1, 32'h00000088, 1'b1, 1'b0, 32'h0,        4'd9},  // R9 status read
    '{3'b001, 12'h305, 5'd2,  32'h1234567B, 5'd0,  2'd3, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 32'h1234567B, 4'd10}, // R10 mode 3
    '{3'b010, 12'h305, 5'd0,  32'h0,        5'd10, 2'd3, 1'b0, 1'b1, 32'h12345678, 1'b1, 1'b0, 32'h0,        4'd10}, // R10 read
    '{3'b101, 12'h305, 5'd1,  32'h0,        5'd0,  2'd3, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 32'h00000001, 4'd10}, // R10 mode 1
    '{3'b010, 12'h305, 5'd0,  32'h0,        5'd11, 2'd3, 1'b0, 1'b1, 32'h00000001, 1'b1, 1'b0, 32'h0,        4'd10}, // R10 read
    '{3'b010, 12'hF12, 5'd0,  32'h0,        5'd12, 2'd3, 1'b0, 1'b1, 32'h5A5A0001, 1'b1, 1'b0, 32'h0,        4'd3},  // R3 RO read
    '{3'b001, 12'hF12, 5'd1,  32'h0,        5'd13, 2'd3, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd7},  // R7 RO write
    '{3'b010, 12'hF12, 5'd6,  32'h0,        5'd14, 2'd3, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd7},  // R7 zero value, nonzero index
    '{3'b010, 12'hCC0, 5'd0,  32'h0,        5'd15, 2'd0, 1'b0, 1'b1, 32'h00C0FFEE, 1'b1, 1'b0, 32'h0,        4'd5},  // R5 user ok
    '{3'b010, 12'h340, 5'd0,  32'h0,        5'd16, 2'd1, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd5},  // R5 sup to machine
    '{3'b001, 12'h140, 5'd1,  32'hCAFEF00D, 5'd17, 2'd1, 1'b0, 1'b1, 32'h0,        1'b1, 1'b1, 32'hCAFEF00D, 4'd5},  // R5 sup ok
    '{3'b010, 12'h140, 5'd0,  32'h0,        5'd18, 2'd0, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd5},  // R5 user to sup
    '{3'b010, 12'h140, 5'd0,  32'h0,        5'd18, 2'd3, 1'b0, 1'b1, 32'hCAFEF00D, 1'b1, 1'b0, 32'h0,        4'd9},  // R9 all bits kept
    '{3'b010, 12'h341, 5'd0,  32'h0,        5'd19, 2'd3, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd6},  // R6 unmapped
    '{3'b000, 12'h340, 5'd1,  32'h1,        5'd20, 2'd3, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd1},  // R1 bad funct3
    '{3'b100, 12'h340, 5'd1,  32'h1,        5'd20, 2'd3, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd1},  // R1 bad funct3
    '{3'b001, 12'h340, 5'd1,  32'h00000099, 5'd21, 2'd1, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        4'd8},  // R8 refused write
    '{3'b010, 12'h340, 5'd0,  32'h0,        5'd22, 2'd3, 1'b0, 1'b1, 32'h00000015, 1'b1, 1'b0, 32'h0,        4'd8}   // R8 value unchanged
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] t_f3, input logic [11:0] t_addr,
                       input logic [4:0] t_src, input logic [31:0] t_rs1,
                       input logic [4:0] t_rd, input logic [1:0] t_priv);
    @(negedge clk);
    valid = 1'b1; f3 = t_f3; addr = t_addr; src = t_src;
    rs1v = t_rs1; rd = t_rd; priv = t_priv;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !ill && !rdwe && !crd && !cwe && rdata == 0, "R11", "reset outputs",
        {27'd0, done, ill, rdwe, crd, cwe}, 32'h0);
    rst_n = 1'b1;
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd1, 2'd3);
    chk(done && rdwe && rdata == 32'h0, "R11", "scratch after reset", rdata, 32'h0);
    @(negedge clk);
    chk(!done, "R11", "done is a single pulse", {31'd0, done}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VEC[i].req, i);
      issue(VEC[i].f3, VEC[i].addr, VEC[i].src, VEC[i].rs1, VEC[i].rd, VEC[i].priv);
      chk(done, rq, "done", {31'd0, done}, 32'h1);
      chk(ill == VEC[i].ill, rq, "illegal", {31'd0, ill}, {31'd0, VEC[i].ill});
      chk(rdwe == VEC[i].rdwe, rq, "rd_we", {31'd0, rdwe}, {31'd0, VEC[i].rdwe});
      chk(crd == VEC[i].rflag, rq, "csr_rd", {31'd0, crd}, {31'd0, VEC[i].rflag});
      chk(cwe == VEC[i].we, rq, "csr_we", {31'd0, cwe}, {31'd0, VEC[i].we});
      if (VEC[i].rdwe) begin
        chk(rdata == VEC[i].rdat, rq, "rd_data", rdata, VEC[i].rdat);
        chk(rdidx == VEC[i].rd, rq, "rd_idx", {27'd0, rdidx}, {27'd0, VEC[i].rd});
      end
      if (VEC[i].we) begin
        chk(cwdata == VEC[i].wdat, rq, "csr_wdata", cwdata, VEC[i].wdat);
        chk(cwaddr == VEC[i].addr, rq, "csr_waddr", {20'd0, cwaddr}, {20'd0, VEC[i].addr});
      end
    end

    // R8 unmapped write leaves scratch intact
    issue(3'b001, 12'h7C0, 5'd1, 32'h55555555, 5'd3, 2'd3);
    chk(ill && !cwe, "R8", "unmapped write refused", {30'd0, ill, cwe}, 32'h2);
    issue(3'b010, 12'h340, 5'd0, 32'h0, 5'd3, 2'd3);
    chk(rdata == 32'h15, "R8", "scratch after refusal", rdata, 32'h15);

    // R11 reset clears CSRs mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(3'b010, 12'h140, 5'd0, 32'h0, 5'd3, 2'd3);
    chk(rdata == 32'h0, "R11", "sup scratch cleared", rdata, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule